// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Cycle Sequencer

This block runs single-bit SPI flash cycles on behalf of software through a small word-addressed register window. Software never writes raw command bytes into a cycle. It first fills an eight-entry table of one-byte opcodes and gives each entry a two-bit kind. It also loads a 24-bit flash address, an optional prefix opcode and up to 64 bytes of buffer data. It then writes a control word that picks a table entry by index and sets the go bit.

The engine drives one chip-select frame: the chosen opcode, then three address bytes if the entry's kind carries an address, then the data bytes. Data bytes are shifted out of the buffer for write kinds and captured into the buffer for read kinds. If the atomic bit is set, the prefix opcode (typically a write-enable) goes out first as a one-byte frame of its own. Chip select is then released briefly before the main frame. A lockdown bit freezes the opcode table, the kind register and the prefix register until reset.

Top module: `spi_menu_seq`

## Requirements
- R1: After reset the chip select is high, SCLK is low, the status word (address 1) reads 0, the divider (address 7) reads 1 and the opcode table reads 0.
- R2: Control word (address 0): bit 0 go, bit 2 atomic, bits 6:4 table index, bits 13:8 data byte count minus one, bit 14 data-phase enable. A cycle's first main-frame byte is the table entry at that index. Entries 0-3 are bytes 0-3 of address 5 (entry i at bits 8i+7:8i), and entries 4-7 are the same layout in address 6.
- R3: Each entry's kind sits at bits 2i+1:2i of address 4, with 0 = read without address, 1 = write without address, 2 = read with address and 3 = write with address. Kinds 2 and 3 send the 24-bit address of address 2 right after the opcode, high byte first. Kinds 0 and 1 send no address.
- R4: With data enabled, count+1 bytes follow the header (1 to 64). Write kinds send buffer bytes 0, 1, ... and read kinds send 0x00 while storing the received bytes into buffer bytes 0, 1, .... Buffer word w is at address 16+w and holds byte 4w+k at bits 8k+7:8k. Without data enabled, the frame ends after the header.
- R5: With the atomic bit set, the prefix opcode (address 3, bits 7:0) is sent as a one-byte frame first. Chip select then stays high for at least 2 SCLK periods before the main frame.
- R6: Status bit 0 is high while a cycle runs. Bit 1 (done) sets when the main frame ends. Bit 2 is the error flag. Writing 1 to bit 1 or bit 2 clears only that flag.
- R7: A go write while a cycle runs is ignored (no extra frame, and the running cycle is not changed) and sets the error flag.
- R8: Writing 1 to status bit 15 sets the lockdown, which reads back at bit 15 and stays set until reset. While it is set, writes to addresses 3, 4, 5 and 6 are ignored.
- R9: SPI mode 0. SCLK idles low and has a period of 2*max(D,1) clocks, where D is address 7 bits 7:0. Bytes go out MSB first, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The assertions assume that software leaves the address, kind and table registers alone while a cycle runs. Go writes while busy are the one exception, and they are exercised on purpose. The assertions also assume the flash model changes MISO only away from the rising SCLK edge. The stimulus reprograms registers only between cycles, which it detects by polling the done flag. Its flash model samples the pins half a clock after each edge and updates MISO only after it sees SCLK fall or chip select drop, so no sample lands on a changing input.

// File: rtl/spi_menu_seq.sv
module spi_menu_seq #(
  parameter int BUF_BYTES = 64,
  parameter int AW = 6,
  parameter int DIV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            spi_csn,
  output logic            spi_sclk,
  output logic            spi_mosi,
  input  logic            spi_miso
);
  localparam int CNT_W    = $clog2(BUF_BYTES);
  localparam int WORDS    = BUF_BYTES / 4;
  localparam int WI_W     = $clog2(WORDS);
  localparam int BI_W     = CNT_W + 2;
  localparam int DCYC_BIT = 8 + CNT_W;
  localparam logic [AW-1:0] BUF_BASE = AW'(16);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_GAP, S_MAIN} state_t;
  state_t state;

  logic [15:0]      ctrl_q;
  logic             st_done, st_err, lock_q;
  logic [23:0]      addr_q;
  logic [7:0]       preop_q;
  logic [15:0]      optype_q;
  logic [63:0]      menu_q;
  logic [DIV_W-1:0] div_q;

  logic [7:0]       c_op;
  logic [1:0]       c_ty;
  logic             c_dcyc;
  logic [CNT_W-1:0] c_cnt;
  logic [23:0]      c_addr;

  logic [DIV_W-1:0] div_cnt;
  logic             hi;
  logic [2:0]       bit_i;
  logic [BI_W-1:0]  byte_i;
  logic [1:0]       gap_n;
  logic [7:0]       sh, rx, nxt;
  logic [7:0]       dbuf [BUF_BYTES];

  logic             busy, tick, go_wr, buf_wr, st_we, in_buf;
  logic [DIV_W-1:0] half;
  logic [BI_W-1:0]  hdr, last_idx, nb;
  logic [2:0]       sel;
  logic [WI_W-1:0]  wi;
  logic [CNT_W-1:0] didx, st_idx;

  assign busy     = state != S_IDLE;
  assign half     = (div_q == '0) ? DIV_W'(1) : div_q;
  assign tick     = div_cnt == half - DIV_W'(1);
  assign hdr      = c_ty[1] ? BI_W'(4) : BI_W'(1);
  assign last_idx = hdr - BI_W'(1) + (c_dcyc ? BI_W'(c_cnt) + BI_W'(1) : BI_W'(0));
  assign nb       = byte_i + BI_W'(1);
  assign didx     = CNT_W'(nb - hdr);
  assign st_idx   = CNT_W'(byte_i - hdr);
  assign sel      = reg_wdata[6:4];
  assign go_wr    = reg_we && reg_addr == '0 && reg_wdata[0];
  assign in_buf   = reg_addr >= BUF_BASE && (reg_addr - BUF_BASE) < AW'(WORDS);
  assign wi       = WI_W'(reg_addr - BUF_BASE);
  assign buf_wr   = reg_we && in_buf;
  assign st_we    = state == S_MAIN && tick && hi && bit_i == 3'd7 &&
                    c_dcyc && !c_ty[0] && byte_i >= hdr;

  assign spi_csn  = !(state == S_PRE || state == S_MAIN);
  assign spi_sclk = hi;
  assign spi_mosi = !spi_csn && sh[7];

  always_comb begin
    if (c_ty[1] && nb == BI_W'(1))      nxt = c_addr[23:16];
    else if (c_ty[1] && nb == BI_W'(2)) nxt = c_addr[15:8];
    else if (c_ty[1] && nb == BI_W'(3)) nxt = c_addr[7:0];
    else if (c_ty[0])                   nxt = dbuf[didx];
    else                                nxt = 8'h00;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr >= BUF_BASE) begin
      if (in_buf)
        reg_rdata = {dbuf[{wi, 2'd3}], dbuf[{wi, 2'd2}], dbuf[{wi, 2'd1}], dbuf[{wi, 2'd0}]};
    end else begin
      case (reg_addr[3:0])
        4'd0: reg_rdata = {16'h0, ctrl_q};
        4'd1: reg_rdata = {16'h0, lock_q, 12'h0, st_err, st_done, busy};
        4'd2: reg_rdata = {8'h0, addr_q};
        4'd3: reg_rdata = {24'h0, preop_q};
        4'd4: reg_rdata = {16'h0, optype_q};
        4'd5: reg_rdata = menu_q[31:0];
        4'd6: reg_rdata = menu_q[63:32];
        4'd7: reg_rdata = 32'(div_q);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (buf_wr)
      for (int k = 0; k < 4; k++) dbuf[{wi, 2'(k)}] <= reg_wdata[8*k +: 8];
    if (st_we) dbuf[st_idx] <= rx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ctrl_q   <= '0;
      st_done  <= 1'b0;
      st_err   <= 1'b0;
      lock_q   <= 1'b0;
      addr_q   <= '0;
      preop_q  <= '0;
      optype_q <= '0;
      menu_q   <= '0;
      div_q    <= DIV_W'(1);
      c_op     <= '0;
      c_ty     <= '0;
      c_dcyc   <= 1'b0;
      c_cnt    <= '0;
      c_addr   <= '0;
      div_cnt  <= '0;
      hi       <= 1'b0;
      bit_i    <= '0;
      byte_i   <= '0;
      gap_n    <= '0;
      sh       <= '0;
      rx       <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          AW'(0): if (!busy) ctrl_q <= {reg_wdata[15:1], 1'b0};
          AW'(1): begin
            if (reg_wdata[1])  st_done <= 1'b0;
            if (reg_wdata[2])  st_err  <= 1'b0;
            if (reg_wdata[15]) lock_q  <= 1'b1;
          end
          AW'(2): addr_q <= reg_wdata[23:0];
          AW'(3): if (!lock_q) preop_q  <= reg_wdata[7:0];
          AW'(4): if (!lock_q) optype_q <= reg_wdata[15:0];
          AW'(5): if (!lock_q) menu_q[31:0]  <= reg_wdata;
          AW'(6): if (!lock_q) menu_q[63:32] <= reg_wdata;
          AW'(7): div_q <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (go_wr && busy) st_err <= 1'b1;

      if (busy) div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);

      case (state)
        S_IDLE: if (go_wr) begin
          c_op    <= menu_q[{sel, 3'b000} +: 8];
          c_ty    <= optype_q[{sel, 1'b0} +: 2];
          c_dcyc  <= reg_wdata[DCYC_BIT];
          c_cnt   <= reg_wdata[8 +: CNT_W];
          c_addr  <= addr_q;
          div_cnt <= '0;
          hi      <= 1'b0;
          bit_i   <= '0;
          byte_i  <= '0;
          if (reg_wdata[2]) begin
            state <= S_PRE;
            sh    <= preop_q;
          end else begin
            state <= S_MAIN;
            sh    <= menu_q[{sel, 3'b000} +: 8];
          end
        end
        S_PRE, S_MAIN: if (tick) begin
          if (!hi) begin
            hi <= 1'b1;
            rx <= {rx[6:0], spi_miso};
          end else begin
            hi <= 1'b0;
            if (bit_i == 3'd7) begin
              bit_i <= '0;
              if (state == S_PRE) begin
                state <= S_GAP;
                gap_n <= '0;
              end else if (byte_i == last_idx) begin
                state   <= S_IDLE;
                st_done <= 1'b1;
              end else begin
                byte_i <= nb;
                sh     <= nxt;
              end
            end else begin
              bit_i <= bit_i + 3'd1;
              sh    <= {sh[6:0], 1'b0};
            end
          end
        end
        S_GAP: if (tick) begin
          gap_n <= gap_n + 2'd1;
          if (gap_n == 2'd3) begin
            state  <= S_MAIN;
            sh     <= c_op;
            byte_i <= '0;
            bit_i  <= '0;
            hi     <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_menu_seq_chk.sv
module spi_menu_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        csn,
  input logic        sclk,
  input logic        mosi,
  input logic        lock,
  input logic [63:0] menu,
  input logic        done,
  input logic        err,
  input logic        go_wr
);
  assert_idle_csn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> csn);

  assert_sclk_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !sclk);

  assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> (!sclk || $stable(mosi)));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  assert_lock_menu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(menu));

  assert_busy_go_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_wr) |=> err);

  assert_done_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
endmodule

bind spi_menu_seq spi_menu_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .csn(spi_csn), .sclk(spi_sclk),
  .mosi(spi_mosi), .lock(lock_q), .menu(menu_q), .done(st_done),
  .err(st_err), .go_wr(go_wr)
);

// File: tb/spi_menu_seq_tb_top.sv
module spi_menu_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic spi_csn, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  always #5 clk = ~clk;

  spi_menu_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int nchk = 0;
  int nfail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 29 + 90) & 255);
  endfunction
  function automatic logic [7:0] opc(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] wdat(int d, int seed);
    return 8'((d * 7 + seed * 13 + 1) & 255);
  endfunction

  // flash model, sampled half a clock after each edge
  bit armed = 0;
  logic pcs = 1'b1, psclk = 1'b0;
  int pos = 0, bitc = 0, tot_fr = 0, rise_n = 0;
  logic [7:0] shin = '0;
  logic [7:0] tmp;
  logic [7:0] fb [0:3][0:71];
  int flen [0:3];
  longint fall_t [0:3];
  longint rise_t [0:3];
  longint rt [0:3][0:1];

  always @(negedge clk) if (armed) begin
    if (pcs && !spi_csn) begin
      pos = 0; bitc = 0; shin = '0; rise_n = 0;
      fall_t[tot_fr % 4] = cyc;
      tmp = pat(0); spi_miso = tmp[7];
    end
    if (!pcs && spi_csn) begin
      flen[tot_fr % 4] = pos;
      rise_t[tot_fr % 4] = cyc;
      tot_fr = tot_fr + 1;
    end
    if (!spi_csn && spi_sclk && !psclk) begin
      shin = {shin[6:0], spi_mosi};
      if (rise_n < 2) rt[tot_fr % 4][rise_n] = cyc;
      rise_n = rise_n + 1;
      bitc = bitc + 1;
      if (bitc == 8) begin
        if (pos < 72) fb[tot_fr % 4][pos] = shin;
        pos = pos + 1;
        bitc = 0;
      end
    end
    if (!spi_csn && !spi_sclk && psclk) begin
      tmp = pat(pos); spi_miso = tmp[7 - bitc];
    end
    pcs = spi_csn;
    psclk = spi_sclk;
  end

  task automatic ck(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 6'(a); #1; d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 6000; i++) begin
      rd(1, s);
      if (s[1]) break;
    end
    ck(s[1] && !s[0], "R6 done set, busy clear after cycle", s, 32'h2);
  endtask

  task automatic run_cycle(input int idx, input int ty, input bit dcyc, input int cnt,
                           input bit atomic, input int half, input logic [23:0] adr, input int seed);
    logic [31:0] r;
    int base, nexp, m, hdr, len;
    logic [7:0] b;
    wr(7, 32'(half));
    wr(4, 32'(ty) << (2 * idx));
    wr(2, {8'h0, adr});
    wr(3, 32'h06);
    for (int w = 0; w < (cnt + 3) / 4; w++)
      wr(16 + w, {wdat(4*w+3, seed), wdat(4*w+2, seed), wdat(4*w+1, seed), wdat(4*w, seed)});
    wr(1, 32'h6);
    base = tot_fr;
    wr(0, 32'h1 | (32'(atomic) << 2) | (32'(idx) << 4) | (32'(cnt - 1) << 8) | (32'(dcyc) << 14));
    wait_done();
    repeat (2) @(negedge clk);
    nexp = atomic ? 2 : 1;
    ck(tot_fr - base == nexp, "R5 frame count", 32'(tot_fr - base), 32'(nexp));
    if (tot_fr - base != nexp) return;
    if (atomic) begin
      ck(flen[base % 4] == 1, "R5 prefix frame length", 32'(flen[base % 4]), 32'd1);
      ck(fb[base % 4][0] == 8'h06, "R5 prefix opcode", 32'(fb[base % 4][0]), 32'h06);
      ck(fall_t[(base + 1) % 4] - rise_t[base % 4] >= 4 * half, "R5 chip-select gap",
         32'(fall_t[(base + 1) % 4] - rise_t[base % 4]), 32'(4 * half));
    end
    m = (base + nexp - 1) % 4;
    hdr = (ty >= 2) ? 4 : 1;
    len = hdr + (dcyc ? cnt : 0);
    ck(flen[m] == len, "R4 main frame length", 32'(flen[m]), 32'(len));
    ck(fb[m][0] == opc(idx), "R2 opcode from menu", 32'(fb[m][0]), 32'(opc(idx)));
    ck(rt[m][1] - rt[m][0] == 2 * half, "R9 SCLK period", 32'(rt[m][1] - rt[m][0]), 32'(2 * half));
    if (ty >= 2) begin
      ck(fb[m][1] == adr[23:16], "R3 address high byte", 32'(fb[m][1]), 32'(adr[23:16]));
      ck(fb[m][2] == adr[15:8],  "R3 address mid byte",  32'(fb[m][2]), 32'(adr[15:8]));
      ck(fb[m][3] == adr[7:0],   "R3 address low byte",  32'(fb[m][3]), 32'(adr[7:0]));
    end
    if (dcyc && flen[m] == len) begin
      for (int d = 0; d < cnt; d++) begin
        if (ty % 2 == 1) begin
          ck(fb[m][hdr + d] == wdat(d, seed), "R4 write data byte", 32'(fb[m][hdr + d]), 32'(wdat(d, seed)));
        end else begin
          ck(fb[m][hdr + d] == 8'h00, "R4 read dummy MOSI", 32'(fb[m][hdr + d]), 32'h0);
          rd(16 + d / 4, r);
          b = r[8 * (d % 4) +: 8];
          ck(b == pat(hdr + d), "R4 read data in buffer", 32'(b), 32'(pat(hdr + d)));
        end
      end
    end
  endtask

  task automatic run_all();
    logic [31:0] r;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1;
    rd(1, r); ck(r == 32'h0, "R1 status after reset", r, 32'h0);
    rd(7, r); ck(r == 32'h1, "R1 divider after reset", r, 32'h1);
    rd(5, r); ck(r == 32'h0, "R1 menu after reset", r, 32'h0);
    ck(spi_csn == 1'b1 && spi_sclk == 1'b0, "R1 SPI idle pins", {30'h0, spi_csn, spi_sclk}, 32'h2);

    wr(5, {opc(3), opc(2), opc(1), opc(0)});
    wr(6, {opc(7), opc(6), opc(5), opc(4)});
    rd(6, r); ck(r == {opc(7), opc(6), opc(5), opc(4)}, "R2 menu readback", r, {opc(7), opc(6), opc(5), opc(4)});

    // near-exhaustive sweep: every index with every kind
    for (int idx = 0; idx < 8; idx++)
      for (int ty = 0; ty < 4; ty++)
        run_cycle(idx, ty, ((idx + ty) % 5) != 0, (idx * 3 + ty) % 6 + 1, (idx % 3) == 0,
                  1 + (idx + ty) % 3, 24'(24'h010203 * (idx + 1)) ^ 24'(ty << 12), idx * 4 + ty);

    // full-depth read
    run_cycle(5, 2, 1'b1, 64, 1'b0, 1, 24'hABCDEF, 3);

    // full-depth write with a go issued while busy (R7)
    wr(7, 32'h1); wr(4, 32'h3 << 4); wr(2, 32'h00FF00);
    for (int w = 0; w < 16; w++)
      wr(16 + w, {wdat(4*w+3, 9), wdat(4*w+2, 9), wdat(4*w+1, 9), wdat(4*w, 9)});
    wr(1, 32'h6);
    base = tot_fr;
    wr(0, 32'h1 | (32'd2 << 4) | (32'd63 << 8) | (32'h1 << 14));
    rd(1, r); ck(r[0] == 1'b1, "R6 busy while running", r, 32'h1);
    wr(0, 32'h1 | 32'h4 | (32'd0 << 4));
    wait_done();
    repeat (2) @(negedge clk);
    rd(1, r); ck(r[2] == 1'b1, "R7 error flag after go while busy", r, 32'h6);
    ck(tot_fr - base == 1, "R7 extra go made no frame", 32'(tot_fr - base), 32'd1);
    ck(flen[base % 4] == 68, "R7 running cycle kept its length", 32'(flen[base % 4]), 32'd68);
    ck(fb[base % 4][0] == opc(2), "R7 running cycle kept its opcode", 32'(fb[base % 4][0]), 32'(opc(2)));
    ck(fb[base % 4][67] == wdat(63, 9), "R4 last of 64 write bytes", 32'(fb[base % 4][67]), 32'(wdat(63, 9)));

    // write-one-to-clear, one flag at a time
    wr(1, 32'h2);
    rd(1, r); ck(r[2:1] == 2'b10, "R6 clear done keeps error", r, 32'h4);
    wr(1, 32'h4);
    rd(1, r); ck(r == 32'h0, "R6 clear error", r, 32'h0);

    // lockdown
    wr(3, 32'h06); wr(4, 32'h1234);
    wr(1, 32'h8000);
    rd(1, r); ck(r[15] == 1'b1, "R8 lock reads back", r, 32'h8000);
    wr(5, 32'hFFFF_FFFF); wr(6, 32'h0); wr(4, 32'hFFFF); wr(3, 32'hAA);
    rd(5, r); ck(r == {opc(3), opc(2), opc(1), opc(0)}, "R8 menu low frozen", r, {opc(3), opc(2), opc(1), opc(0)});
    rd(6, r); ck(r == {opc(7), opc(6), opc(5), opc(4)}, "R8 menu high frozen", r, {opc(7), opc(6), opc(5), opc(4)});
    rd(4, r); ck(r == 32'h1234, "R8 kind register frozen", r, 32'h1234);
    rd(3, r); ck(r == 32'h06, "R8 prefix frozen", r, 32'h06);
    wr(1, 32'h0);
    rd(1, r); ck(r[15] == 1'b1, "R8 lock stays set", r, 32'h8000);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule